// File: doc/BRIEF.md
# Grouped Interrupt Combiner

The combiner collects thirty-two level-sensitive interrupt lines and folds them into four combined requests, one per group of eight adjacent lines, for a primary interrupt controller. Each raw line first crosses a two-flop synchronizer. It is then gated by its own enable bit. The gated result is the line's status bit. A group's request is high while any of its status bits is high. Next to each request the block gives the position of the lowest-numbered active line in that group. A handler can use this index to service lines in priority order without scanning the status word.

Software reaches the enables through a single-cycle register port. One address turns enable bits on and a second address turns them off; in both cases only the bit positions written with a one are affected. A third address returns the masked status word. Because set and clear are separate operations, a driver never needs a read-modify-write to change one line.

Top module: `irqc_combiner`

## Requirements
- R1: After synchronous reset every enable bit is 0, so reads of offset 0x0 return 0x0000_0000.
- R2: A write to offset 0x0 sets each enable bit whose wdata bit is 1; enable bits at positions written with 0 keep their value. The change is visible from the cycle after the write edge.
- R3: A write to offset 0x4 clears each enable bit whose wdata bit is 1; other enable bits keep their value.
- R4: Reads of offset 0x0 and of offset 0x4 both return the current 32-bit enable word (bit n is line n).
- R5: A read of offset 0xC returns the status word, where bit n is 1 exactly when synchronized line n is high and enable bit n is 1.
- R6: A change on irq_in shows in status, grp_irq and grp_idx two clock edges after it is first sampled, and not earlier.
- R7: grp_irq[g] is the OR of status bits 8*g through 8*g+7, for g = 0..3.
- R8: grp_idx[3*g+2:3*g] is the offset (0..7) of the lowest set status bit inside group g; it reads 0 when grp_irq[g] is 0.
- R9: Lines are level-sensitive: a status bit stays 1 for as long as its input is held high and enabled, and returns to 0 two edges after the input falls.
- R10: Writes to any offset other than 0x0 and 0x4 leave the enables unchanged; reads of any offset other than 0x0, 0x4 and 0xC return 0.
- R11: Writing 0xFF shifted left by 8*g to offset 0x4 disables all eight lines of group g and drops grp_irq[g], leaving the other groups' enables untouched.
- R12: A line whose enable bit is 0 never sets its status bit and never contributes to its group's request, however long its input stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Raw level-sensitive interrupt lines, line n on bit n |
| wr_en | input | 1 | Register write strobe, acts on the rising edge |
| addr | input | 4 | Register byte offset (0x0 set, 0x4 clear, 0xC status) |
| wdata | input | 32 | Write data, one bit per line |
| rdata | output | 32 | Read data for the offset on addr, combinational |
| grp_irq | output | 4 | Combined request of each group of eight lines |
| grp_idx | output | 12 | Three-bit lowest-active-line index per group, group g at bits 3*g+2:3*g |

## Verification
On every cycle the assertions check that a set write leaves every written-one bit enabled while keeping all other bits, that a clear write leaves every written-one bit disabled, that writes to unused offsets leave the enables still, and that each group's index points at an active line with no active line below it. The bench's scenarios must show what these cannot: the two-edge latency from a raw line to the status word, level behaviour while a line is held and after it falls, the full-group clear, and reads at every offset. A behavioural model based on a delay queue checks rdata, grp_irq and grp_idx on every cycle of a directed phase and then of a random phase.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int NUM_GROUPS      = 4;
    localparam int LINES_PER_GROUP = 8;
    localparam int NUM_LINES       = NUM_GROUPS * LINES_PER_GROUP;
    localparam int IDX_W           = $clog2(LINES_PER_GROUP);
    localparam int ADDR_W          = 4;

    localparam logic [ADDR_W-1:0] OFS_EN_SET = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_EN_CLR = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'hC;

    typedef enum logic [1:0] {
        REG_SET  = 2'd0,
        REG_CLR  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                 we;
        reg_sel_e             sel;
        logic [NUM_LINES-1:0] data;
    } reg_req_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
    } grp_result_t;

    function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_EN_SET: s = REG_SET;
            OFS_EN_CLR: s = REG_CLR;
            OFS_STATUS: s = REG_STAT;
            default:    s = REG_NONE;
        endcase
        return s;
    endfunction

    // Scan from the top down so the last hit is the lowest position.
    function automatic grp_result_t first_active(input logic [LINES_PER_GROUP-1:0] v);
        grp_result_t r;
        r.valid = |v;
        r.idx   = '0;
        for (int i = LINES_PER_GROUP - 1; i >= 0; i--) begin
            if (v[i]) r.idx = IDX_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage[i] <= '0;
        end else begin
            stage[0] <= d;
            for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign q = stage[STAGES-1];

endmodule

// File: rtl/irqc_enable_regs.sv
module irqc_enable_regs
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  reg_req_t             req,
    output logic [NUM_LINES-1:0] en
);
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] en_d;

    always_comb begin
        en_d = en_q;
        if (req.we) begin
            case (req.sel)
                REG_SET: en_d = en_q | req.data;
                REG_CLR: en_d = en_q & ~req.data;
                default: en_d = en_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) en_q <= '0;
        else     en_q <= en_d;
    end

    assign en = en_q;

    // R2: written ones become enabled, written zeros keep their old value
    a_r2_set_ones: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == REG_SET) |=> ((en & $past(req.data)) == $past(req.data)));
    a_r2_set_keeps: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == REG_SET) |=> ((en & ~$past(req.data)) == ($past(en) & ~$past(req.data))));
    // R3: written ones become disabled
    a_r3_clr_ones: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == REG_CLR) |=> ((en & $past(req.data)) == '0));
    // R10: writes to any other offset change nothing
    a_r10_other_write: assert property (@(posedge clk) disable iff (rst)
        (req.sel == REG_STAT || req.sel == REG_NONE || !req.we) |=> $stable(en));

endmodule

// File: rtl/irqc_group.sv
module irqc_group
    import irqc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LINES_PER_GROUP-1:0] status,
    output grp_result_t                res
);
    assign res = first_active(status);

    // R8: the reported line is active and nothing below it is
    a_r8_idx_active: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> status[res.idx]);
    a_r8_idx_lowest: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> ((status & ((LINES_PER_GROUP'(1) << res.idx) - LINES_PER_GROUP'(1))) == '0));
    // R8: idle group reports index zero
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !res.valid |-> (res.idx == '0 && status == '0));

endmodule

// File: rtl/irqc_combiner.sv
module irqc_combiner
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_LINES-1:0]          irq_in,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [NUM_LINES-1:0]          wdata,
    output logic [NUM_LINES-1:0]          rdata,
    output logic [NUM_GROUPS-1:0]         grp_irq,
    output logic [NUM_GROUPS*IDX_W-1:0]   grp_idx
);
    reg_req_t             req;
    logic [NUM_LINES-1:0] lines_sync;
    logic [NUM_LINES-1:0] en;
    logic [NUM_LINES-1:0] status;

    assign req.we   = wr_en;
    assign req.sel  = decode_offset(addr);
    assign req.data = wdata;

    irqc_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (lines_sync)
    );

    irqc_enable_regs u_regs (
        .clk (clk),
        .rst (rst),
        .req (req),
        .en  (en)
    );

    assign status = lines_sync & en;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        grp_result_t res;
        irqc_group u_group (
            .clk    (clk),
            .rst    (rst),
            .status (status[g*LINES_PER_GROUP +: LINES_PER_GROUP]),
            .res    (res)
        );
        assign grp_irq[g]                 = res.valid;
        assign grp_idx[g*IDX_W +: IDX_W]  = res.idx;
    end

    always_comb begin
        case (req.sel)
            REG_SET, REG_CLR: rdata = en;
            REG_STAT:         rdata = status;
            default:          rdata = '0;
        endcase
    end

    // R12: a request never stands for a group whose lines are all disabled
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        a_r12_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
            (en[g*LINES_PER_GROUP +: LINES_PER_GROUP] == '0) |-> !grp_irq[g]);
    end

endmodule

// File: tb/irqc_combiner_tb.sv
module irqc_combiner_tb_top;

    localparam int NL = 32;
    localparam int NG = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    addr = 4'h0;
    logic [NL-1:0] wdata = '0;
    logic [NL-1:0] rdata;
    logic [NG-1:0] grp_irq;
    logic [11:0]   grp_idx;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqc_combiner dut_i (
        .clk     (clk),
        .rst     (rst),
        .irq_in  (irq_in),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .grp_irq (grp_irq),
        .grp_idx (grp_idx)
    );

    // Behavioural reference: enable word plus a queue of past input samples.
    logic [NL-1:0] m_en = '0;
    logic [NL-1:0] m_hist [$];

    always @(posedge clk) begin
        if (rst) begin
            m_en = '0;
            m_hist = {32'h0, 32'h0};
        end else begin
            if (wr_en && addr == 4'h0) m_en = m_en | wdata;
            if (wr_en && addr == 4'h4) m_en = m_en & ~wdata;
            m_hist.push_front(irq_in);
            void'(m_hist.pop_back());
        end
    end

    function automatic logic [NL-1:0] m_status();
        return m_hist[1] & m_en;
    endfunction

    function automatic logic [NL-1:0] m_rdata();
        case (addr)
            4'h0, 4'h4: return m_en;
            4'hC:       return m_status();
            default:    return '0;
        endcase
    endfunction

    task automatic expect_val(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_model();
        logic [NL-1:0] st;
        logic [NG-1:0] e_irq;
        logic [11:0]   e_idx;
        st = m_status();
        e_irq = '0;
        e_idx = '0;
        for (int g = 0; g < NG; g++) begin
            for (int b = 7; b >= 0; b--) begin
                if (st[g*8+b]) begin
                    e_irq[g] = 1'b1;
                    e_idx[g*3 +: 3] = 3'(b);
                end
            end
        end
        if (addr == 4'hC)                     expect_val("R5 model rdata", rdata, m_rdata());
        else if (addr == 4'h0 || addr == 4'h4) expect_val("R4 model rdata", rdata, m_rdata());
        else                                  expect_val("R10 model rdata", rdata, m_rdata());
        expect_val("R7 model grp_irq", {28'h0, grp_irq}, {28'h0, e_irq});
        expect_val("R8 model grp_idx", {20'h0, grp_idx}, {20'h0, e_idx});
    endtask

    task automatic cyc();
        @(negedge clk);
        if (!rst) compare_model();
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [NL-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        cyc();
        wr_en = 1'b0; wdata = '0;
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        addr = 4'h0;
        #1 expect_val("R1 reset enables", rdata, 32'h0);

        reg_write(4'h0, 32'h8100_0F24);
        addr = 4'h0; #1 expect_val("R2 set", rdata, 32'h8100_0F24);
        reg_write(4'h0, 32'h0000_00F0);
        addr = 4'h0; #1 expect_val("R2 keep zeros", rdata, 32'h8100_0FF4);
        reg_write(4'h4, 32'h0000_0014);
        addr = 4'h0; #1 expect_val("R3 clear", rdata, 32'h8100_0FE0);
        addr = 4'h4; #1 expect_val("R4 read via clear offset", rdata, 32'h8100_0FE0);
        reg_write(4'h8, 32'hFFFF_FFFF);
        reg_write(4'hC, 32'hFFFF_FFFF);
        addr = 4'h0; #1 expect_val("R10 stray writes ignored", rdata, 32'h8100_0FE0);
        addr = 4'h8; #1 expect_val("R10 unused read", rdata, 32'h0);

        addr = 4'hC;
        irq_in = 32'hFFFF_FFFF;
        cyc();
        #1 expect_val("R6 one edge not yet", rdata, 32'h0);
        cyc();
        #1 expect_val("R6 R5 status after two edges", rdata, 32'h8100_0FE0);
        expect_val("R7 group requests", {28'h0, grp_irq}, 32'hB);
        expect_val("R8 group indexes", {20'h0, grp_idx}, {20'h0, 3'd0, 3'd0, 3'd0, 3'd5});

        irq_in = 32'h0100_0040;
        repeat (2) cyc();
        #1 expect_val("R8 lowest moves", {20'h0, grp_idx}, {20'h0, 3'd0, 3'd0, 3'd0, 3'd6});
        expect_val("R7 sparse groups", {28'h0, grp_irq}, 32'h9);

        irq_in = 32'h0000_0010;
        repeat (4) cyc();
        #1 expect_val("R12 disabled line quiet", rdata, 32'h0);
        expect_val("R12 no group request", {28'h0, grp_irq}, 32'h0);

        irq_in = 32'hFFFF_FFFF;
        repeat (2) cyc();
        reg_write(4'h4, 32'h0000_FF00);
        addr = 4'h0; #1 expect_val("R11 group clear enables", rdata, 32'h8100_00E0);
        expect_val("R11 group request dropped", {28'h0, grp_irq}, 32'h9);

        addr = 4'hC;
        repeat (5) cyc();
        #1 expect_val("R9 held line stays", rdata, 32'h8100_00E0);
        irq_in = 32'h0;
        cyc();
        #1 expect_val("R9 one edge after fall", rdata, 32'h8100_00E0);
        cyc();
        #1 expect_val("R9 cleared after fall", rdata, 32'h0);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr_en = r[0] & r[1];
            addr = {r[3:2], 2'b00};
            wdata = $urandom;
            if (r[4]) irq_in = $urandom;
            cyc();
        end
        wr_en = 1'b0;
        cyc();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule